// File: doc/BRIEF.md
# Decomposed Sine Amplitude Generator

This block turns a wide phase word into a signed 16-bit sine sample without a full-length sine table. The two top phase bits pick the quadrant. The angle bits below them are mirrored when the sine is falling and then split into a coarse part `a` and a fine part `b`. The sample is built as sin(a)cos(b) + cos(a)sin(b).

Three small tables do the work. One holds sin(a) and one holds cos(b). A third, narrow table gives the small cross term cos(a)sin(b) directly, and it is addressed by a shortened `a` and a shortened `b`. One multiplier forms sin(a)cos(b) and one adder adds the cross term. The sum is rounded to the output width and clamped at positive full scale. In the lower half of the period the result is negated.

A phase source such as an accumulator feeds `in_phase` with a strobe. A converter takes `out_sample` whenever `out_valid` is high. The block accepts a new phase on every cycle, and the latency is fixed.

Top module: `dsin_gen`

## Requirements
- R1: A phase sampled with `in_valid` high at a rising edge gives its result on `out_valid`/`out_sample` after the fourth rising edge, counting the sampling edge as the first. `out_valid` is high for exactly one cycle per accepted phase.
- R2: While no result is delivered, `out_sample` keeps its last value. A phase presented with `in_valid` low has no effect on either output.
- R3: While `rst` is high at a rising edge, `out_valid` goes to 0 and `out_sample` to 0.
- R4: The phase fields are: bits [31:30] are the quadrant q, bits [29:16] are a 14-bit angle u, and bits [15:0] are not used. With θ = 2π·(q·2^14 + u + 0.5)/2^16, `out_sample` lies within ±4 of round(32768·sin θ), clamped to [-32767, 32767].
- R5: Folding is exact. The result for quadrant 1 with angle u equals the result for quadrant 0 with angle ~u. The results for quadrants 2 and 3 are the exact negatives of those for quadrants 0 and 1 with the same u.
- R6: At the crest (q=0, u=0x3FFF) the output is exactly 32767, and at the trough (q=2, u=0x3FFF) it is exactly -32767. The code -32768 never appears.
- R7: Phase words that differ only in bits [15:0] give the same sample.
- R8: With `in_valid` high on consecutive cycles, one result comes out per cycle, in input order. Each result equals the result the same phase gives when presented alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Phase strobe |
| in_phase | input | 32 | Phase word: quadrant in the top two bits, then the angle |
| out_valid | output | 1 | High for one cycle with each result |
| out_sample | output | 16 | Signed two's-complement sine sample |

## Verification
The clamp at positive full scale and the quadrant negation are applied in the same final stage. A phase at the trough therefore needs both at once. The bench provokes this with the trough word and the mirrored word of quadrant 3. It requires exactly -32767, so a negation applied before the clamp, or no clamp at all, shows up as -32768. The output-hold behaviour and a full-rate stream also meet in one cycle when the stream ends. The bench compares every streamed sample with its isolated result, and it checks that `out_valid` drops on the cycle after the last one.

// File: rtl/dsin_pkg.sv
package dsin_pkg;
  localparam real HALF_PI = 1.5707963267948966;

  // Round a non-negative real to the nearest integer.
  function automatic int fix_round(real v);
    return $rtoi(v + 0.5);
  endfunction
endpackage

// File: rtl/dsin_fold.sv
// Stage 1: quadrant folding and split of the folded angle into coarse/fine parts.
module dsin_fold #(
  parameter int PHASE_W = 32,
  parameter int A_W     = 8,
  parameter int B_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PHASE_W-1:0] in_phase,
  output logic              s1_valid,
  output logic [A_W-1:0]    s1_a,
  output logic [B_W-1:0]    s1_b,
  output logic              s1_neg
);
  localparam int X_W   = A_W + B_W;
  localparam int LOW_W = PHASE_W - 2 - X_W;

  logic [X_W-1:0] x;

  always_comb begin
    x = in_phase[PHASE_W-3 -: X_W];
    if (in_phase[PHASE_W-2]) x = ~x;
  end

  generate
    if (LOW_W > 0) begin : g_low
      logic unused_low;
      assign unused_low = ^in_phase[LOW_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_a   <= x[X_W-1 -: A_W];
      s1_b   <= x[B_W-1:0];
      s1_neg <= in_phase[PHASE_W-1];
    end
  end
endmodule

// File: rtl/dsin_rom_bank.sv
// Stage 2: three registered table reads (ROMs inferable as block RAM).
module dsin_rom_bank
  import dsin_pkg::*;
#(
  parameter int A_W       = 8,
  parameter int B_W       = 6,
  parameter int CS_DROP_A = 2,
  parameter int CS_DROP_B = 1,
  parameter int TAB_W     = 18,
  parameter int CS_W      = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [A_W-1:0]   s1_a,
  input  logic [B_W-1:0]   s1_b,
  input  logic             s1_neg,
  output logic             s2_valid,
  output logic [TAB_W-1:0] s2_sin_a,
  output logic [TAB_W-1:0] s2_cos_b,
  output logic [CS_W-1:0]  s2_cross,
  output logic             s2_neg
);
  localparam int  FRAC_W = TAB_W - 1;
  localparam int  SA_N   = 1 << A_W;
  localparam int  CB_N   = 1 << B_W;
  localparam int  CA_W   = A_W - CS_DROP_A;
  localparam int  CBB_W  = B_W - CS_DROP_B;
  localparam int  CS_N   = 1 << (CA_W + CBB_W);
  localparam real D_A    = HALF_PI / real'(SA_N);
  localparam real D_B    = D_A / real'(CB_N);
  localparam real SCALE  = real'(1 << FRAC_W);

  logic [TAB_W-1:0] sin_rom   [SA_N];
  logic [TAB_W-1:0] cos_rom   [CB_N];
  logic [CS_W-1:0]  cross_rom [CS_N];

  initial begin
    real ta;
    real tb;
    for (int i = 0; i < SA_N; i++)
      sin_rom[i] = TAB_W'(fix_round($sin(real'(i) * D_A) * SCALE));
    for (int j = 0; j < CB_N; j++)
      cos_rom[j] = TAB_W'(fix_round($cos((real'(j) + 0.5) * D_B) * SCALE));
    for (int k = 0; k < CS_N; k++) begin
      ta = (real'((k >> CBB_W) << CS_DROP_A)
            + (real'(1 << CS_DROP_A) - 1.0) / 2.0) * D_A;
      tb = (real'((k % (1 << CBB_W)) << CS_DROP_B)
            + real'(1 << CS_DROP_B) / 2.0) * D_B;
      cross_rom[k] = CS_W'(fix_round($cos(ta) * $sin(tb) * SCALE));
    end
  end

  always_ff @(posedge clk) begin
    s2_sin_a <= sin_rom[s1_a];
    s2_cos_b <= cos_rom[s1_b];
    s2_cross <= cross_rom[{s1_a[A_W-1 -: CA_W], s1_b[B_W-1 -: CBB_W]}];
    s2_neg   <= s1_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
  end
endmodule

// File: rtl/dsin_combine.sv
// Stages 3 and 4: multiply, add the cross term, round, clamp and apply sign.
module dsin_combine #(
  parameter int TAB_W = 18,
  parameter int CS_W  = 11,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    s2_valid,
  input  logic [TAB_W-1:0]        s2_sin_a,
  input  logic [TAB_W-1:0]        s2_cos_b,
  input  logic [CS_W-1:0]         s2_cross,
  input  logic                    s2_neg,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int FRAC_W = TAB_W - 1;
  localparam int SUM_W  = TAB_W + 1;
  localparam int SH     = FRAC_W + 1 - OUT_W;
  localparam int MAG_W  = SUM_W + 1 - SH;
  localparam logic [SUM_W:0]   RND_V  = (SUM_W+1)'(1 << (SH - 1));
  localparam logic [OUT_W-1:0] MAXP   = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [MAG_W-1:0] MAXP_W = MAG_W'(MAXP);

  logic [2*TAB_W-1:0] prod;
  logic [SUM_W-1:0]   prod_hi;
  logic [CS_W-1:0]    cross_d;
  logic               neg_d;
  logic               v3;
  logic [SUM_W:0]     sum;
  logic [SUM_W:0]     rsum;
  logic [MAG_W-1:0]   mag_w;
  logic [OUT_W-1:0]   mag;
  logic [OUT_W-1:0]   signed_n;
  logic               unused_bits;

  assign prod = s2_sin_a * s2_cos_b;

  always_ff @(posedge clk) begin
    prod_hi <= prod[2*TAB_W-1 -: SUM_W];
    cross_d <= s2_cross;
    neg_d   <= s2_neg;
  end

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= s2_valid;
  end

  always_comb begin
    sum      = {1'b0, prod_hi} + {{(SUM_W + 1 - CS_W){1'b0}}, cross_d};
    rsum     = sum + RND_V;
    mag_w    = rsum[SUM_W:SH];
    mag      = (mag_w > MAXP_W) ? MAXP : mag_w[OUT_W-1:0];
    signed_n = neg_d ? (~mag + 1'b1) : mag;
  end

  assign unused_bits = ^{prod[FRAC_W-1:0], rsum[SH-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= v3;
      if (v3) out_sample <= signed'(signed_n);
    end
  end
endmodule

// File: rtl/dsin_gen.sv
module dsin_gen #(
  parameter int PHASE_W   = 32,
  parameter int OUT_W     = 16,
  parameter int A_W       = 8,
  parameter int B_W       = 6,
  parameter int CS_DROP_A = 2,
  parameter int CS_DROP_B = 1,
  parameter int TAB_W     = 18,
  parameter int CS_W      = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  logic             s1_valid, s1_neg;
  logic [A_W-1:0]   s1_a;
  logic [B_W-1:0]   s1_b;
  logic             s2_valid, s2_neg;
  logic [TAB_W-1:0] s2_sin_a, s2_cos_b;
  logic [CS_W-1:0]  s2_cross;

  dsin_fold #(.PHASE_W(PHASE_W), .A_W(A_W), .B_W(B_W)) u_fold (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .s1_valid(s1_valid), .s1_a(s1_a), .s1_b(s1_b), .s1_neg(s1_neg)
  );

  dsin_rom_bank #(
    .A_W(A_W), .B_W(B_W), .CS_DROP_A(CS_DROP_A), .CS_DROP_B(CS_DROP_B),
    .TAB_W(TAB_W), .CS_W(CS_W)
  ) u_rom (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_a(s1_a), .s1_b(s1_b),
    .s1_neg(s1_neg), .s2_valid(s2_valid), .s2_sin_a(s2_sin_a),
    .s2_cos_b(s2_cos_b), .s2_cross(s2_cross), .s2_neg(s2_neg)
  );

  dsin_combine #(.TAB_W(TAB_W), .CS_W(CS_W), .OUT_W(OUT_W)) u_comb (
    .clk(clk), .rst(rst), .s2_valid(s2_valid), .s2_sin_a(s2_sin_a),
    .s2_cos_b(s2_cos_b), .s2_cross(s2_cross), .s2_neg(s2_neg),
    .out_valid(out_valid), .out_sample(out_sample)
  );
endmodule

// File: rtl/dsin_chk.sv
module dsin_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [PHASE_W-1:0]      in_phase,
  input logic                    out_valid,
  input logic signed [OUT_W-1:0] out_sample
);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1: result strobe follows the input strobe by four edges
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R2: sample is held when no result is delivered
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd1 && !out_valid) |-> $stable(out_sample));

  // R6: most negative code never produced
  a_r6_no_most_neg: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sample != MOST_NEG));

  // R5: sign of the result follows the half of the period
  a_r5_sign: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && out_valid) |->
      ($past(in_phase[PHASE_W-1], 4) ? (out_sample <= 0) : (out_sample >= 0)));
endmodule

bind dsin_gen dsin_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/tb_dsin_gen.sv
module tb_dsin_gen;
  localparam int  PW  = 32;
  localparam int  OW  = 16;
  localparam int  TOL = 4;
  localparam real PI  = 3.141592653589793;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic                 in_valid;
  logic [PW-1:0]        in_phase;
  logic                 out_valid;
  logic signed [OW-1:0] out_sample;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  dsin_gen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_phase(in_phase),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_near(string req, string what, int act, int exp);
    int d;
    d = act - exp;
    n_chk++;
    if (d > TOL || d < -TOL) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (+/-%0d)", req, what, act, exp, TOL);
    end
  endtask

  function automatic int ideal(logic [31:0] p);
    real th, v;
    int  r;
    th = 2.0 * PI * (real'(p[31:30]) * 16384.0 + real'(p[29:16]) + 0.5) / 65536.0;
    v  = 32768.0 * $sin(th);
    r  = (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    if (r > 32767)  r = 32767;
    if (r < -32767) r = -32767;
    return r;
  endfunction

  task automatic run_one(input logic [31:0] p, output int s, output bit v);
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = p;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    v = out_valid;
    s = int'(out_sample);
  endtask

  task automatic t_reset();
    check_eq("R3", "out_valid in reset", int'(out_valid), 0);
    check_eq("R3", "out_sample in reset", int'(out_sample), 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = 32'h1000_0000;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check_eq("R1", $sformatf("out_valid after %0d edges", k), int'(out_valid), (k == 4) ? 1 : 0);
    end
  endtask

  task automatic t_accuracy();
    logic [31:0] pts [10] = '{32'h0000_0000, 32'h1234_5678, 32'h2AAA_0000,
                              32'h4000_0000, 32'h5555_5555, 32'h8000_FFFF,
                              32'hA5A5_1234, 32'hC000_0000, 32'hE000_0000,
                              32'hFFFF_FFFF};
    int s;
    bit v;
    foreach (pts[i]) begin
      run_one(pts[i], s, v);
      check_eq("R1", "valid with result", int'(v), 1);
      check_near("R4", $sformatf("phase %h", pts[i]), s, ideal(pts[i]));
    end
    for (int i = 0; i < 48; i++) begin
      logic [31:0] p;
      p = 32'h0153_0000 * i + 32'h0000_3A7F;
      run_one(p, s, v);
      check_near("R4", $sformatf("sweep phase %h", p), s, ideal(p));
    end
  endtask

  task automatic t_fold();
    logic [13:0] us [4] = '{14'h0000, 14'h0123, 14'h2A5C, 14'h3FFE};
    int s0, s1, s2, s3;
    bit v;
    foreach (us[i]) begin
      run_one({2'd0, us[i], 16'h0}, s0, v);
      run_one({2'd1, ~us[i], 16'h0}, s1, v);
      run_one({2'd2, us[i], 16'h0}, s2, v);
      run_one({2'd3, ~us[i], 16'h0}, s3, v);
      check_eq("R5", $sformatf("mirror q1 u=%h", us[i]), s1, s0);
      check_eq("R5", $sformatf("negate q2 u=%h", us[i]), s2, -s0);
      check_eq("R5", $sformatf("negate q3 u=%h", us[i]), s3, -s0);
    end
  endtask

  task automatic t_saturate();
    int s;
    bit v;
    run_one({2'd0, 14'h3FFF, 16'h0}, s, v);
    check_eq("R6", "crest", s, 32767);
    run_one({2'd1, 14'h0000, 16'h0}, s, v);
    check_eq("R6", "crest mirrored", s, 32767);
    run_one({2'd2, 14'h3FFF, 16'h0}, s, v);
    check_eq("R6", "trough", s, -32767);
    run_one({2'd3, 14'h0000, 16'hFFFF}, s, v);
    check_eq("R6", "trough mirrored", s, -32767);
  endtask

  task automatic t_low_bits();
    int s_a, s_b, s_c;
    bit v;
    run_one(32'h6B2D_0000, s_a, v);
    run_one(32'h6B2D_FFFF, s_b, v);
    run_one(32'h6B2D_8421, s_c, v);
    check_eq("R7", "low bits all ones", s_b, s_a);
    check_eq("R7", "low bits mixed", s_c, s_a);
  endtask

  task automatic t_hold();
    int s;
    bit v;
    run_one(32'h3000_0000, s, v);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_phase = 32'hC000_0000 + k * 32'h0700_0000;
      check_eq("R2", $sformatf("no valid, cycle %0d", k), int'(out_valid), 0);
      check_eq("R2", $sformatf("held sample, cycle %0d", k), int'(out_sample), s);
    end
  endtask

  task automatic t_stream();
    localparam int N = 8;
    logic [31:0] ph [N];
    int          ref_s [N];
    bit          v;
    for (int i = 0; i < N; i++) begin
      ph[i] = 32'h0000_1111 + i * 32'h2345_0000;
      run_one(ph[i], ref_s[i], v);
    end
    for (int i = 0; i < N + 5; i++) begin
      @(negedge clk);
      if (i >= 4 && i < N + 4) begin
        check_eq("R8", $sformatf("stream valid %0d", i - 4), int'(out_valid), 1);
        check_eq("R8", $sformatf("stream sample %0d", i - 4), int'(out_sample), ref_s[i - 4]);
      end
      if (i == N + 4)
        check_eq("R8", "valid drops after stream", int'(out_valid), 0);
      in_valid = (i < N);
      in_phase = (i < N) ? ph[i] : 32'h0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst      = 1'b1;
    in_valid = 1'b0;
    in_phase = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_latency();
    t_accuracy();
    t_fold();
    t_saturate();
    t_low_bits();
    t_hold();
    t_stream();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule